// File: doc/BRIEF.md
# Sobel Direction and Threshold Kernel

This block takes one 3x3 neighbourhood of unsigned gray-scale pixels per accepted sample and decides whether the centre pixel sits on an edge. It also reports which of eight compass directions the edge faces. Four signed gradients are formed, two of them along the diagonals. The gradient with the largest magnitude sets the candidate direction. One eighth of the magnitude of the gradient at right angles to it is added, and the total is compared against a fixed threshold.

Window storage, line buffering and image sequencing belong to the surrounding logic. That logic presents a complete window together with a one-cycle valid strobe. Results come back two clock cycles later with their own valid strobe. The result outputs keep their last value between results.

Top module: `sobel_dir_kernel`

## Requirements
- R1: The window pixel at row r, column c (row 0 at the top, column 0 at the left) sits at bits [(3r+c)*PIX_W +: PIX_W] of `in_win`. Four signed gradients are formed, where p(r,c) is that pixel:
  - diagonal A = p(0,1)+2p(0,2)+p(1,2) − p(1,0)−2p(2,0)−p(2,1)
  - vertical = p(0,0)+2p(0,1)+p(0,2) − p(2,0)−2p(2,1)−p(2,2)
  - horizontal = p(0,2)+2p(1,2)+p(2,2) − p(0,0)−2p(1,0)−p(2,0)
  - diagonal B = p(1,0)+2p(0,0)+p(0,1) − p(2,1)−2p(2,2)−p(1,2)
  
  Each value lies within ±4·(2^PIX_W−1).
- R2: The chosen gradient is the one of largest absolute value. Its sign picks the direction code in `out_dir`. A non-negative value picks the first code of each pair and a negative value picks the second: horizontal gives East 000 / West 001, vertical gives North 010 / South 011, diagonal B gives Northwest 100 / Southeast 101, diagonal A gives Northeast 110 / Southwest 111.
- R3: When magnitudes tie for the maximum, the first in the order diagonal A, vertical, horizontal, diagonal B is chosen.
- R4: The perpendicular partner of vertical is horizontal, and the partner of diagonal A is diagonal B (and the reverse in both cases). The partner's magnitude, shifted right by PERP_SHIFT (3) with truncation, is added to the maximum magnitude.
- R5: `out_edge` is 1 exactly when that sum is greater than or equal to THRESH (80). A window of nine equal pixels never gives an edge.
- R6: When `out_edge` is 0 in a result, `out_dir` is 000.
- R7: `out_valid` is high for one cycle two rising edges after each rising edge at which `in_valid` is high. It is low otherwise. Windows presented with `in_valid` low produce no result.
- R8: While `out_valid` is low, `out_edge` and `out_dir` hold the last result.
- R9: While `rst_n` is low, `out_valid`, `out_edge` and `out_dir` are 0. After `rst_n` rises, the internal reset releases at the second rising edge. Samples are accepted from the third rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window on `in_win` is a sample |
| in_win | input | 9*PIX_W | Nine window pixels, row-major |
| out_valid | output | 1 | Result strobe |
| out_edge | output | 1 | Centre pixel lies on an edge |
| out_dir | output | 3 | Direction code of the edge |

## Verification
The bench builds the block with its default values: 8-bit pixels, threshold 80 and a perpendicular shift of 3. With these values the full-scale gradient of ±1020 can be reached with pixels of 255. Single-pixel windows of value 100 put each of the eight direction codes on the output. Small pixel values land the score exactly on 79 and 80, and others make the truncated eighth of the perpendicular term decide the result. Handmade windows with two-way and three-way ties check the selection order. Random windows, with random gaps and with garbage on idle cycles, are compared on every clock against a behavioural model, and a reset is applied in the middle of the run.

// File: rtl/sobel_dir_pkg.sv
package sobel_dir_pkg;

  localparam int N_ORIENT = 4;
  localparam int N_TAPS   = 9;

  typedef logic [1:0] orient_t;
  typedef logic [2:0] dir_t;

  // orientation index doubles as tie priority (lower wins)
  localparam orient_t ORI_DIAG_A = 2'd0;
  localparam orient_t ORI_VERT   = 2'd1;
  localparam orient_t ORI_HORZ   = 2'd2;
  localparam orient_t ORI_DIAG_B = 2'd3;

  function automatic orient_t perp_of(input orient_t o);
    orient_t r;
    case (o)
      ORI_DIAG_A: r = ORI_DIAG_B;
      ORI_VERT:   r = ORI_HORZ;
      ORI_HORZ:   r = ORI_VERT;
      default:    r = ORI_DIAG_A;
    endcase
    return r;
  endfunction

  function automatic dir_t dir_code(input orient_t o, input logic neg);
    dir_t r;
    case (o)
      ORI_DIAG_A: r = {2'b11, neg};
      ORI_VERT:   r = {2'b01, neg};
      ORI_HORZ:   r = {2'b00, neg};
      default:    r = {2'b10, neg};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sobel_rst_sync.sv
module sobel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sobel_grad_stage.sv
module sobel_grad_stage
  import sobel_dir_pkg::*;
#(
  parameter int PIX_W  = 8,
  localparam int GRAD_W = PIX_W + 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [N_TAPS*PIX_W-1:0]              in_win,
  output logic [N_ORIENT-1:0][GRAD_W-1:0]      grad_q,
  output logic                                 v_q
);
  logic signed [GRAD_W-1:0] px [N_TAPS];
  logic [N_ORIENT-1:0][GRAD_W-1:0] grad_d;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign px[t] = signed'({{(GRAD_W-PIX_W){1'b0}}, in_win[t*PIX_W +: PIX_W]});
  end

  // tap index = 3*row + col
  for (genvar g = 0; g < N_ORIENT; g++) begin : g_orient
    logic signed [GRAD_W-1:0] pos_s;
    logic signed [GRAD_W-1:0] neg_s;
    if (g == int'(ORI_DIAG_A)) begin : g_da
      assign pos_s = px[1] + (px[2] <<< 1) + px[5];
      assign neg_s = px[3] + (px[6] <<< 1) + px[7];
    end else if (g == int'(ORI_VERT)) begin : g_v
      assign pos_s = px[0] + (px[1] <<< 1) + px[2];
      assign neg_s = px[6] + (px[7] <<< 1) + px[8];
    end else if (g == int'(ORI_HORZ)) begin : g_h
      assign pos_s = px[2] + (px[5] <<< 1) + px[8];
      assign neg_s = px[0] + (px[3] <<< 1) + px[6];
    end else begin : g_db
      assign pos_s = px[3] + (px[0] <<< 1) + px[1];
      assign neg_s = px[7] + (px[8] <<< 1) + px[5];
    end
    assign grad_d[g] = pos_s - neg_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grad_q <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) grad_q <= grad_d;
    end
  end
endmodule

// File: rtl/sobel_dir_select.sv
module sobel_dir_select
  import sobel_dir_pkg::*;
#(
  parameter int GRAD_W = 11,
  localparam int MAG_W = GRAD_W - 1
) (
  input  logic [N_ORIENT-1:0][GRAD_W-1:0] grad,
  output logic [MAG_W-1:0]                max_mag,
  output logic [MAG_W-1:0]                perp_mag,
  output dir_t                            cand_dir
);
  logic [MAG_W-1:0] mag [N_ORIENT];
  logic [N_ORIENT-1:0] sgn;
  logic [GRAD_W-1:0] absv [N_ORIENT];
  orient_t best;

  always_comb begin
    for (int o = 0; o < N_ORIENT; o++) begin
      sgn[o]  = grad[o][GRAD_W-1];
      absv[o] = sgn[o] ? (~grad[o] + 1'b1) : grad[o];
      mag[o]  = absv[o][MAG_W-1:0];
    end
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    best = ORI_DIAG_A;
    for (int o = 1; o < N_ORIENT; o++) begin
      if (mag[o] > mag[best]) best = orient_t'(o);
    end
  end

  always_comb begin
    max_mag  = mag[best];
    perp_mag = mag[perp_of(best)];
    cand_dir = dir_code(best, sgn[best]);
  end
endmodule

// File: rtl/sobel_thresh_stage.sv
module sobel_thresh_stage
  import sobel_dir_pkg::*;
#(
  parameter int MAG_W      = 10,
  parameter int THRESH     = 80,
  parameter int PERP_SHIFT = 3,
  localparam int SCORE_W   = MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [MAG_W-1:0] max_mag,
  input  logic [MAG_W-1:0] perp_mag,
  input  dir_t             cand_dir,
  output logic             out_valid,
  output logic             out_edge,
  output dir_t             out_dir
);
  logic [SCORE_W-1:0] score;
  logic               edge_d;
  dir_t               dir_d;

  always_comb begin
    score  = {1'b0, max_mag} + SCORE_W'(perp_mag >> PERP_SHIFT);
    edge_d = (score >= SCORE_W'(THRESH));
    dir_d  = edge_d ? cand_dir : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_edge  <= 1'b0;
      out_dir   <= 3'b000;
    end else begin
      out_valid <= en;
      if (en) begin
        out_edge <= edge_d;
        out_dir  <= dir_d;
      end
    end
  end
endmodule

// File: rtl/sobel_dir_kernel.sv
module sobel_dir_kernel
  import sobel_dir_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int THRESH     = 80,
  parameter int PERP_SHIFT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [9*PIX_W-1:0]      in_win,
  output logic                    out_valid,
  output logic                    out_edge,
  output logic [2:0]              out_dir
);
  localparam int GRAD_W = PIX_W + 3;
  localparam int MAG_W  = GRAD_W - 1;

  logic rst_sync_n;
  logic [N_ORIENT-1:0][GRAD_W-1:0] grad_q;
  logic v1_q;
  logic [MAG_W-1:0] max_mag;
  logic [MAG_W-1:0] perp_mag;
  dir_t cand_dir;
  dir_t dir_q;

  sobel_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sobel_grad_stage #(.PIX_W(PIX_W)) u_grad (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_win(in_win),
    .grad_q(grad_q), .v_q(v1_q)
  );

  sobel_dir_select #(.GRAD_W(GRAD_W)) u_sel (
    .grad(grad_q), .max_mag(max_mag), .perp_mag(perp_mag), .cand_dir(cand_dir)
  );

  sobel_thresh_stage #(.MAG_W(MAG_W), .THRESH(THRESH), .PERP_SHIFT(PERP_SHIFT)) u_thr (
    .clk(clk), .rst_n(rst_sync_n), .en(v1_q), .max_mag(max_mag), .perp_mag(perp_mag),
    .cand_dir(cand_dir), .out_valid(out_valid), .out_edge(out_edge), .out_dir(dir_q)
  );

  assign out_dir = dir_q;
endmodule

// File: rtl/sobel_dir_kernel_chk.sv
module sobel_dir_kernel_chk #(
  parameter int PIX_W  = 8,
  parameter int GRAD_W = PIX_W + 3,
  parameter int MAG_W  = GRAD_W - 1
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  in_valid,
  input logic [9*PIX_W-1:0]    in_win,
  input logic                  out_valid,
  input logic                  out_edge,
  input logic [2:0]            out_dir,
  input logic [3:0][GRAD_W-1:0] grad_q,
  input logic [MAG_W-1:0]      max_mag,
  input logic [MAG_W-1:0]      perp_mag
);
  localparam int LIM = 4 * ((1 << PIX_W) - 1);

  logic [1:0] since_rst;
  logic       flat_win;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    flat_win = 1'b1;
    for (int t = 1; t < 9; t++)
      if (in_win[t*PIX_W +: PIX_W] != in_win[0 +: PIX_W]) flat_win = 1'b0;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_nodir_when_noedge_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_edge) |-> (out_dir == 3'b000));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst >= 2'd1 && !out_valid) |-> ($stable(out_edge) && $stable(out_dir)));

  assert_flat_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst >= 2'd2 && out_valid && $past(in_valid, 2) && $past(flat_win, 2)) |-> !out_edge);

  assert_perp_not_above_max_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    max_mag >= perp_mag);

  for (genvar g = 0; g < 4; g++) begin : g_rng
    assert_grad_range_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($signed(grad_q[g]) <= LIM) && ($signed(grad_q[g]) >= -LIM));
  end
endmodule

bind sobel_dir_kernel sobel_dir_kernel_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid), .in_win(in_win),
  .out_valid(out_valid), .out_edge(out_edge), .out_dir(out_dir),
  .grad_q(grad_q), .max_mag(max_mag), .perp_mag(perp_mag)
);

// File: tb/sobel_dir_kernel_bench.sv
module sobel_dir_kernel_bench;
  localparam int CLK_P = 10;
  localparam int PW    = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [9*PW-1:0] in_win;
  logic out_valid, out_edge;
  logic [2:0] out_dir;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model history: h1 = driven last negedge, h2 = the one before
  bit              h1_v, h2_v;
  logic [9*PW-1:0] h1_w, h2_w;
  bit              held_e;
  bit [2:0]        held_d;

  always #(CLK_P/2) clk = ~clk;

  sobel_dir_kernel u_sobel_dir_kernel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win),
    .out_valid(out_valid), .out_edge(out_edge), .out_dir(out_dir)
  );

  function automatic void model(input logic [9*PW-1:0] w, output bit e, output bit [2:0] d);
    int p[9];
    int g[4];
    int m[4];
    int best, pr, score;
    bit [2:0] codes [4][2];
    codes[0][0] = 3'b110; codes[0][1] = 3'b111;
    codes[1][0] = 3'b010; codes[1][1] = 3'b011;
    codes[2][0] = 3'b000; codes[2][1] = 3'b001;
    codes[3][0] = 3'b100; codes[3][1] = 3'b101;
    for (int i = 0; i < 9; i++) p[i] = int'(w[i*PW +: PW]);
    g[0] = (p[1] + 2*p[2] + p[5]) - (p[3] + 2*p[6] + p[7]);
    g[1] = (p[0] + 2*p[1] + p[2]) - (p[6] + 2*p[7] + p[8]);
    g[2] = (p[2] + 2*p[5] + p[8]) - (p[0] + 2*p[3] + p[6]);
    g[3] = (p[3] + 2*p[0] + p[1]) - (p[7] + 2*p[8] + p[5]);
    for (int i = 0; i < 4; i++) m[i] = (g[i] < 0) ? -g[i] : g[i];
    best = 0;
    for (int i = 1; i < 4; i++) if (m[i] > m[best]) best = i;
    pr = 3 - best;
    score = m[best] + m[pr] / 8;
    e = (score >= 80);
    d = e ? codes[best][g[best] < 0] : 3'b000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e; bit [2:0] d;
    if (h2_v) begin
      model(h2_w, e, d);
      held_e = e; held_d = d;
    end
    chk(out_valid === h2_v, "R7 out_valid", int'(out_valid), int'(h2_v));
    chk(out_edge === held_e, h2_v ? "R5 out_edge" : "R8 out_edge held", int'(out_edge), int'(held_e));
    chk(out_dir === held_d, h2_v ? "R2 out_dir" : "R8 out_dir held", int'(out_dir), int'(held_d));
  endtask

  task automatic step(input bit v, input logic [9*PW-1:0] w);
    @(negedge clk);
    compare();
    in_valid = v;
    in_win   = w;
    h2_v = h1_v; h2_w = h1_w;
    h1_v = v;    h1_w = w;
  endtask

  function automatic logic [9*PW-1:0] px1(input int tap, input int val);
    logic [9*PW-1:0] w = '0;
    w[tap*PW +: PW] = PW'(val);
    return w;
  endfunction

  task automatic directed(input logic [9*PW-1:0] w, input bit e, input bit [2:0] d, input string req);
    step(1'b1, w);
    step(1'b0, '0);
    step(1'b0, '0);
    chk(out_edge === e, req, int'(out_edge), int'(e));
    chk(out_dir === d, req, int'(out_dir), int'(d));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_win = '0;
    h1_v = 0; h2_v = 0; h1_w = '0; h2_w = '0; held_e = 0; held_d = 3'b000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0 && out_edge === 1'b0 && out_dir === 3'b000, "R9 reset outputs",
          int'({out_valid, out_edge, out_dir}), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, '0);
  endtask

  function automatic logic [9*PW-1:0] rand_win(input int mode);
    logic [9*PW-1:0] w;
    for (int t = 0; t < 9; t++) begin
      case (mode)
        0: w[t*PW +: PW] = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00;
        1: w[t*PW +: PW] = PW'($urandom_range(0, 255));
        default: w[t*PW +: PW] = PW'($urandom_range(0, 45));
      endcase
    end
    return w;
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_win = '0;
    h1_v = 0; h2_v = 0; h1_w = '0; h2_w = '0; held_e = 0; held_d = 3'b000;
    do_reset();

    // R1 / R2: single bright pixel of 100 at each outer tap
    directed(px1(1, 100), 1'b1, 3'b010, "R1 R2 top-centre North");
    directed(px1(7, 100), 1'b1, 3'b011, "R1 R2 bottom-centre South");
    directed(px1(5, 100), 1'b1, 3'b000, "R1 R2 mid-right East");
    directed(px1(3, 100), 1'b1, 3'b001, "R1 R2 mid-left West");
    directed(px1(0, 100), 1'b1, 3'b100, "R1 R2 top-left Northwest");
    directed(px1(8, 100), 1'b1, 3'b101, "R1 R2 bottom-right Southeast");
    directed(px1(2, 100), 1'b1, 3'b110, "R1 R2 top-right Northeast");
    directed(px1(6, 100), 1'b1, 3'b111, "R1 R2 bottom-left Southwest");
    // R1 full scale: top row 255 -> vertical 1020 North
    directed({{6{8'h00}}, {3{8'hFF}}}, 1'b1, 3'b010, "R1 full-scale North");
    // R3 three-way tie diag A / vertical / diag B -> diag A
    directed(px1(0, 100) | px1(2, 100), 1'b1, 3'b110, "R3 tie diagA first");
    // R3 vertical vs horizontal tie (190 each), diag A 180 -> North
    directed(px1(1, 100) | px1(5, 100) | px1(6, 10), 1'b1, 3'b010, "R3 tie vertical over horizontal");
    // R5 threshold: score 80 edge, 78 no edge
    directed(px1(2, 40), 1'b1, 3'b110, "R5 score 80");
    directed(px1(2, 39), 1'b0, 3'b000, "R5 R6 score 78");
    // R4 truncated perpendicular: 79 + 9/8 = 80; 78 + 8/8 = 79
    directed(px1(2, 35) | px1(5, 9), 1'b1, 3'b110, "R4 perp adds one");
    directed(px1(2, 35) | px1(5, 8), 1'b0, 3'b000, "R4 R6 score 79");
    // R4 partner is diag B (7/8=0 -> 77), not horizontal (49/8 -> 83)
    directed(px1(2, 35) | px1(5, 7), 1'b0, 3'b000, "R4 partner pairing");
    // R5 flat window
    directed({9{8'hC8}}, 1'b0, 3'b000, "R5 flat window");

    for (int n = 0; n < 3000; n++) begin
      int gap = $urandom_range(0, 3);
      step(1'b1, rand_win(n % 3));
      for (int k = 0; k < gap; k++) step(1'b0, rand_win(1));
      if (n == 1500) do_reset();
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule